// File: doc/BRIEF.md
# Trap and Interrupt Control Unit

This block sits beside the instruction decoder of a small 8-bit processor core. It owns two software-visible registers: a control register that carries a sticky trap flag, a read-only record of where the offending opcode byte sat, and enable bits for three external interrupt inputs; and a vector-base register whose top three bits form the upper part of every interrupt vector the block produces.

When the decoder reports an undefined opcode (including one seen during an interrupt-acknowledge fetch), the block raises the trap flag, notes the byte position, and in the next cycle pulses a request to push the program counter together with a request to restart fetch at logical address zero. Since reset also starts execution at address zero, software tells the two apart by reading the trap flag, which only reset or a software write of zero can clear. Outside a trap cycle, the block picks the highest-priority enabled pending request among the external inputs and the on-chip peripheral sources and presents a registered vector built from the base bits and a fixed per-source code.

Top module: `trap_irq_ctrl`

## Requirements
- R1: After reset the control register reads 0x01 (only the external input 0 enable set), the vector-base register reads 0x00, and vec_valid, trap_push and fetch_redirect are low.
- R2: A cycle with undef_strobe high sets the trap flag (control bit 7) and drives trap_push and fetch_redirect high for exactly the following cycle.
- R3: A software write to the control register with bit 7 equal to 0 clears the trap flag; a write with bit 7 equal to 1 leaves the flag unchanged, so software can never set it.
- R4: Control bit 6 takes the value of undef_pos in the cycle undef_strobe is high (0: opcode starts at stacked PC minus 1; 1: minus 2) and ignores software writes.
- R5: Control bits 2, 1, 0 enable external inputs 2, 1, 0 (irq_req bits 2..0), 1 meaning enabled; peripheral requests (irq_req bits 3 and up) are never masked by them.
- R6: When at least one enabled request is pending and no trap strobe is present, the next cycle shows vec_valid high and vec_out equal to {vector-base bits 7..5, 5-bit code}, where the code is twice the index of the lowest-numbered enabled pending request.
- R7: Vector-base bits 4..0 and control bits 5..3 always read 0 and ignore writes.
- R8: A trap strobe takes priority over vectoring: in the cycle after undef_strobe, vec_valid is low whatever requests are pending.
- R9: If undef_strobe arrives in the same cycle as a software write that clears the trap flag, the flag ends up set.
- R10: reg_rdata shows, one cycle after reg_sel is applied, the selected register (0: control, 1: vector base).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register select: 0 control, 1 vector base |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data of the selected register |
| undef_strobe | input | 1 | Single-cycle pulse from the decoder: undefined opcode fetched |
| undef_pos | input | 1 | Byte position of the undefined opcode (0 second, 1 third) |
| irq_req | input | 7 | Pending requests: bits 2..0 external inputs, bits 6..3 peripherals |
| vec_valid | output | 1 | A vectored request is presented |
| vec_out | output | 8 | Synthesized interrupt vector |
| trap_push | output | 1 | Pulse: push the program counter |
| fetch_redirect | output | 1 | Pulse: resume fetch at logical address zero |

## Verification
The vectoring path is swept over every one of the 128 request patterns under all eight enable combinations and all eight base values, which separates the priority order, the masking of only the external inputs, and the placement of the base bits. Trap sequences are driven with both byte positions, with and without pending requests, and against a same-cycle clearing write, which distinguishes trap priority over vectoring, the one-cycle pulse shape and the set-over-clear rule. Writes of ones and zeros to the flag, position and unused bits show which bits software can and cannot touch.

// File: rtl/trap_irq_pkg.sv
package trap_irq_pkg;
  localparam int DATA_W = 8;
  localparam int N_EXT  = 3;
  localparam int CODE_W = 5;
  localparam int VHI_W  = DATA_W - CODE_W;

  typedef struct packed {
    logic             trap;
    logic             pos;
    logic [N_EXT-1:0] ena;
  } ctrl_t;

  // fixed per-source code: twice the source index
  function automatic logic [CODE_W-1:0] src_code(input int idx);
    return CODE_W'(idx * 2);
  endfunction
endpackage

// File: rtl/trap_ctrl_reg.sv
module trap_ctrl_reg
  import trap_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              undef_strobe,
  input  logic              undef_pos,
  output ctrl_t             ctrl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl.trap <= 1'b0;
      ctrl.pos  <= 1'b0;
      ctrl.ena  <= N_EXT'(1);
    end else begin
      if (wr_en) begin
        if (!wdata[DATA_W-1]) ctrl.trap <= 1'b0;
        ctrl.ena <= wdata[N_EXT-1:0];
      end
      if (undef_strobe) begin
        ctrl.trap <= 1'b1;
        ctrl.pos  <= undef_pos;
      end
    end
  end

  AST_TRAP_SETS: assert property (@(posedge clk) disable iff (rst)
    undef_strobe |=> ctrl.trap) else $error("trap flag not set"); // R2
  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl.trap) |-> $past(undef_strobe)) else $error("trap set without strobe"); // R3
  AST_POS_HELD: assert property (@(posedge clk) disable iff (rst)
    !$past(undef_strobe) |-> $stable(ctrl.pos)) else $error("position bit moved"); // R4
endmodule

// File: rtl/vec_base_reg.sv
module vec_base_reg
  import trap_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [VHI_W-1:0]  vhi
);
  always_ff @(posedge clk) begin
    if (rst)        vhi <= '0;
    else if (wr_en) vhi <= wdata[DATA_W-1 -: VHI_W];
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import trap_irq_pkg::*;
#(
  parameter int NUM_SRC = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req,
  input  logic [N_EXT-1:0]   ena,
  output logic               any,
  output logic [CODE_W-1:0]  code
);
  logic [NUM_SRC-1:0] masked;
  logic [NUM_SRC-1:0] grant;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_mask
    if (g < N_EXT) begin : g_ext
      assign masked[g] = req[g] & ena[g];
    end else begin : g_per
      assign masked[g] = req[g];
    end
  end

  always_comb begin
    grant = '0;
    code  = '0;
    any   = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (masked[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        code     = src_code(i);
        any      = 1'b1;
      end
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)) else $error("multiple grants"); // R6
  AST_GRANT_ANY: assert property (@(posedge clk) disable iff (rst)
    (|req) == 1'b0 |-> !any) else $error("grant without request"); // R6
endmodule

// File: rtl/trap_irq_ctrl.sv
module trap_irq_ctrl
  import trap_irq_pkg::*;
#(
  parameter int N_PERIPH = 4,
  localparam int NUM_SRC = N_EXT + N_PERIPH
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_sel,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               undef_strobe,
  input  logic               undef_pos,
  input  logic [NUM_SRC-1:0] irq_req,
  output logic               vec_valid,
  output logic [DATA_W-1:0]  vec_out,
  output logic               trap_push,
  output logic               fetch_redirect
);
  ctrl_t              ctrl;
  logic [VHI_W-1:0]   vhi;
  logic               any;
  logic [CODE_W-1:0]  code;
  logic [DATA_W-1:0]  ctrl_view;
  logic [DATA_W-1:0]  base_view;

  trap_ctrl_reg u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (reg_wr && !reg_sel),
    .wdata        (reg_wdata),
    .undef_strobe (undef_strobe),
    .undef_pos    (undef_pos),
    .ctrl         (ctrl)
  );

  vec_base_reg u_base (
    .clk   (clk),
    .rst   (rst),
    .wr_en (reg_wr && reg_sel),
    .wdata (reg_wdata),
    .vhi   (vhi)
  );

  irq_prio_enc #(.NUM_SRC(NUM_SRC)) u_enc (
    .clk  (clk),
    .rst  (rst),
    .req  (irq_req),
    .ena  (ctrl.ena),
    .any  (any),
    .code (code)
  );

  assign ctrl_view = {ctrl.trap, ctrl.pos, {(DATA_W-2-N_EXT){1'b0}}, ctrl.ena};
  assign base_view = {vhi, {CODE_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata      <= '0;
      vec_valid      <= 1'b0;
      vec_out        <= '0;
      trap_push      <= 1'b0;
      fetch_redirect <= 1'b0;
    end else begin
      reg_rdata      <= reg_sel ? base_view : ctrl_view;
      trap_push      <= undef_strobe;
      fetch_redirect <= undef_strobe;
      vec_valid      <= any && !undef_strobe;
      vec_out        <= {vhi, code};
    end
  end

  AST_PUSH_CAUSE: assert property (@(posedge clk) disable iff (rst)
    trap_push |-> $past(undef_strobe)) else $error("push without strobe"); // R2
  AST_TRAP_FIRST: assert property (@(posedge clk) disable iff (rst)
    trap_push |-> !vec_valid) else $error("vector during trap"); // R8
  AST_BASE_LOW: assert property (@(posedge clk) disable iff (rst)
    base_view[CODE_W-1:0] == '0) else $error("base low bits set"); // R7
endmodule

// File: tb/trap_irq_ctrl_bench.sv
module trap_irq_ctrl_bench;
  localparam int NP = 4;
  localparam int NS = 3 + NP;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_sel = 1'b0;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          undef_strobe = 1'b0;
  logic          undef_pos = 1'b0;
  logic [NS-1:0] irq_req = '0;
  logic          vec_valid;
  logic [7:0]    vec_out;
  logic          trap_push;
  logic          fetch_redirect;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  trap_irq_ctrl #(.N_PERIPH(NP)) u_trap_irq_ctrl (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .undef_strobe(undef_strobe), .undef_pos(undef_pos), .irq_req(irq_req),
    .vec_valid(vec_valid), .vec_out(vec_out),
    .trap_push(trap_push), .fetch_redirect(fetch_redirect)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    @(negedge clk);
    reg_sel = sel;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic trap(input logic p);
    @(negedge clk);
    undef_strobe = 1'b1; undef_pos = p;
    @(negedge clk);
    undef_strobe = 1'b0;
  endtask

  initial begin : watchdog
    #900000;
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    logic [7:0] expv;
    logic       expok;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 vec_valid", {7'd0, vec_valid}, 8'h00);
    chk("R1 trap_push", {7'd0, trap_push}, 8'h00);
    chk("R1 fetch_redirect", {7'd0, fetch_redirect}, 8'h00);
    rd(1'b0, d); chk("R1 R10 control", d, 8'h01);
    rd(1'b1, d); chk("R1 R10 base", d, 8'h00);

    // R7 unused bits
    wr(1'b1, 8'hFF); rd(1'b1, d); chk("R7 base low bits", d, 8'hE0);
    wr(1'b0, 8'h38); rd(1'b0, d); chk("R7 control 5..3", d, 8'h00);
    // R4 position bit not writable, R3 write 1 does not set
    wr(1'b0, 8'hC7); rd(1'b0, d); chk("R3 R4 write ones", d, 8'h07);

    // R2 R8 trap with pending request, pos 1
    irq_req = 7'b0001000;
    trap(1'b1);
    chk("R2 trap_push pulse", {7'd0, trap_push}, 8'h01);
    chk("R2 fetch_redirect pulse", {7'd0, fetch_redirect}, 8'h01);
    chk("R8 no vector in trap", {7'd0, vec_valid}, 8'h00);
    @(negedge clk);
    chk("R2 trap_push ends", {7'd0, trap_push}, 8'h00);
    chk("R2 fetch_redirect ends", {7'd0, fetch_redirect}, 8'h00);
    chk("R8 vector resumes", {7'd0, vec_valid}, 8'h01);
    irq_req = '0;
    rd(1'b0, d); chk("R2 R4 flag and pos", d, 8'hC7);
    wr(1'b0, 8'hFF); rd(1'b0, d); chk("R3 write one keeps", d, 8'hC7);
    wr(1'b0, 8'h07); rd(1'b0, d); chk("R3 R4 clear keeps pos", d, 8'h47);
    trap(1'b0); rd(1'b0, d); chk("R4 pos 0", d, 8'h87);

    // R9 set wins over same-cycle clear
    wr(1'b0, 8'h07); rd(1'b0, d); chk("R3 cleared", d, 8'h47 & 8'h07 | 8'h00);
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = 8'h07;
    undef_strobe = 1'b1; undef_pos = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; undef_strobe = 1'b0;
    rd(1'b0, d); chk("R9 set over clear", d, 8'hC7);
    wr(1'b0, 8'h07);

    // R5 R6 sweep: base bits x enables x request patterns
    for (int vb = 0; vb < 8; vb++) begin
      wr(1'b1, 8'(vb << 5) | 8'h1F);
      for (int en = 0; en < 8; en++) begin
        wr(1'b0, 8'(en));
        for (int rq = 0; rq < 128; rq++) begin
          @(negedge clk);
          irq_req = 7'(rq);
          @(negedge clk);
          expok = 1'b0; expv = '0;
          for (int i = NS - 1; i >= 0; i--) begin
            if (rq[i] && (i >= 3 || en[i])) begin
              expok = 1'b1;
              expv  = 8'((vb << 5) | (i * 2));
            end
          end
          chk("R5 R6 vec_valid", {7'd0, vec_valid}, {7'd0, expok});
          if (expok) chk("R6 vec_out", vec_out, expv);
        end
      end
    end
    irq_req = '0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule